// File: doc/BRIEF.md
# Multiplexed Grid Scanner with Brightness Control

This block drives a time-multiplexed vacuum fluorescent display with two or three grids. It takes three segment rows, one per grid, and a brightness value as inputs. It produces the active-low grid enables and the segment drive that light one grid at a time. Each grid owns a fixed slot. Within that slot the grid and its segments are on for a number of bit times set by the brightness value, and off for the rest of the slot.

In master role the block runs its own scan counters. It also exports the lit window on `dim_out` and the current grid index on `sync_out`, so that a second device can follow the same scan. In follower role the block ignores its own counters. It chooses a segment row from the code on `sync_in`, gates the segments with `dim_in`, and holds its grid, window and index outputs idle. That lets two devices share one tube with twice the segment count.

All outputs are registered. A synchronous active-high reset returns every output to the dark state.

Top module: `gsd_scanner`

## Requirements
- R1: During reset and after it, `seg` is all zero, `grid_n` is all ones, `dim_out` is 0 and `sync_out` is 0. The captured brightness is 0, so the first grid slot after reset stays dark whatever `bright` is.
- R2: In master role, one bit time lasts TICK_DIV clocks and one grid slot lasts 2^SLOT_BITS bit times. `sync_out` steps through the grid codes 0, 1 (and 2 in three-grid mode), dwelling one slot on each.
- R3: When `dup_sel` is 1 the scan covers two grids, so `grid_n[2]` never goes low and code 2 never appears. When `dup_sel` is 0 the scan covers three grids.
- R4: In master role, each grid is lit for `bright` bit times at the start of its slot, then dark for the remainder of the slot. `bright` is captured at each slot boundary.
- R5: A `bright` value above 2^SLOT_BITS − BLANK is treated as exactly 2^SLOT_BITS − BLANK. Every slot therefore has at least BLANK dark bit times.
- R6: At most one bit of `grid_n` is low at any time. A low bit means that grid is lit.
- R7: In master role, while grid k is low, `seg` equals segment row k (bit i of `seg` is 1 when bit i of the row is 1). While no grid is low, `seg` is zero.
- R8: In master role, `dim_out` is 1 exactly when a grid is low. `sync_out` carries the index of the grid being scanned as a binary number {sync2,sync1}: 0 is grid 0, 1 is grid 1, and 2 is grid 2.
- R9: In master role, `dim_in` and `sync_in` have no effect on any output.
- R10: In follower role, `seg` is selected by `sync_in` and appears one clock after the inputs: code 0 gives `row0`, code 1 gives `row1`, and code 2 gives `row2`. The selected row is ANDed with `dim_in`.
- R11: In follower role, `sync_in` code 3 forces `seg` to zero.
- R12: In follower role, `grid_n` is all ones, and `dim_out` and `sync_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit time is TICK_DIV of its cycles |
| rst | input | 1 | Synchronous reset, active high |
| master | input | 1 | 1 selects master role, 0 selects follower role |
| dup_sel | input | 1 | 1 selects two-grid scanning, 0 selects three-grid scanning |
| bright | input | SLOT_BITS | Lit bit times per grid slot |
| row0 | input | SEG_W | Segment row for grid 0 |
| row1 | input | SEG_W | Segment row for grid 1 |
| row2 | input | SEG_W | Segment row for grid 2 |
| dim_in | input | 1 | Lit window from a master (follower role only) |
| sync_in | input | 2 | Grid code from a master (follower role only) |
| seg | output | SEG_W | Segment drive, 1 = lit |
| grid_n | output | 3 | Grid enables, active low |
| dim_out | output | 1 | Lit window for a follower |
| sync_out | output | 2 | Grid code for a follower |

## Verification
The bench builds the scanner with TICK_DIV=2, SLOT_BITS=5 and BLANK=8. With these values a slot is 64 clocks and the brightness ceiling is 24. Every brightness value, the clamp boundary at 24 and 25, and a full three-grid frame all fit in a few hundred cycles. Measuring over six slots covers whole frames in both two-grid and three-grid mode, so the lit-time totals per grid can be compared exactly.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

    typedef logic [1:0] gcode_t;

    typedef enum logic {
        SCAN_TRIPLEX = 1'b0,
        SCAN_DUPLEX  = 1'b1
    } scan_e;

    localparam int     GRID_CNT   = 3;
    localparam gcode_t CODE_BLANK = 2'b11;

    typedef struct packed {
        logic [GRID_CNT-1:0] grid_n;
        logic                dim;
        gcode_t              code;
    } drive_t;

    localparam drive_t DRIVE_IDLE = '{grid_n: '1, dim: 1'b0, code: 2'b00};

    // One-hot grid select for a code; the blank code selects nothing.
    function automatic logic [GRID_CNT-1:0] grid_sel(input gcode_t c);
        logic [GRID_CNT-1:0] r;
        r = '0;
        if (c != CODE_BLANK) r[c] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/gsd_scan_timer.sv
module gsd_scan_timer
    import gsd_pkg::*;
#(
    parameter int TICK_DIV  = 4,
    parameter int SLOT_BITS = 10,
    parameter int BLANK     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dup_sel,
    input  logic [SLOT_BITS-1:0] bright,
    output gcode_t               gidx,
    output logic                 active
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [SLOT_BITS-1:0] CEIL_V = SLOT_BITS'((1 << SLOT_BITS) - BLANK);

    logic [PW-1:0]        pre_q;
    logic [SLOT_BITS-1:0] bit_q;
    logic [SLOT_BITS-1:0] duty_q;
    gcode_t               gidx_q;
    logic                 tick;
    logic                 slot_end;
    gcode_t               last_g;
    scan_e                mode;
    logic [SLOT_BITS-1:0] duty_new;

    assign mode     = scan_e'(dup_sel);
    assign last_g   = (mode == SCAN_DUPLEX) ? 2'd1 : 2'd2;
    assign tick     = (pre_q == PW'(TICK_DIV - 1));
    assign slot_end = tick && (bit_q == '1);
    assign duty_new = (bright > CEIL_V) ? CEIL_V : bright;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            bit_q  <= '0;
            duty_q <= '0;
            gidx_q <= 2'd0;
        end else begin
            pre_q <= tick ? '0 : pre_q + PW'(1);
            if (tick) bit_q <= bit_q + SLOT_BITS'(1);
            if (slot_end) begin
                duty_q <= duty_new;
                gidx_q <= (gidx_q >= last_g) ? 2'd0 : gidx_q + 2'd1;
            end
        end
    end

    assign gidx   = gidx_q;
    assign active = (bit_q < duty_q);

endmodule

// File: rtl/gsd_row_pick.sv
module gsd_row_pick
    import gsd_pkg::*;
#(
    parameter int SEG_W = 32
) (
    input  logic [SEG_W-1:0] row0,
    input  logic [SEG_W-1:0] row1,
    input  logic [SEG_W-1:0] row2,
    input  gcode_t           code,
    input  logic             gate,
    output logic [SEG_W-1:0] seg
);
    logic [SEG_W-1:0] picked;

    always_comb begin
        unique case (code)
            2'd0:    picked = row0;
            2'd1:    picked = row1;
            2'd2:    picked = row2;
            default: picked = '0;
        endcase
    end

    assign seg = gate ? picked : '0;

endmodule

// File: rtl/gsd_scanner.sv
module gsd_scanner
    import gsd_pkg::*;
#(
    parameter int SEG_W     = 32,
    parameter int TICK_DIV  = 4,
    parameter int SLOT_BITS = 10,
    parameter int BLANK     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 master,
    input  logic                 dup_sel,
    input  logic [SLOT_BITS-1:0] bright,
    input  logic [SEG_W-1:0]     row0,
    input  logic [SEG_W-1:0]     row1,
    input  logic [SEG_W-1:0]     row2,
    input  logic                 dim_in,
    input  logic [1:0]           sync_in,
    output logic [SEG_W-1:0]     seg,
    output logic [2:0]           grid_n,
    output logic                 dim_out,
    output logic [1:0]           sync_out
);
    gcode_t           gidx;
    logic             active;
    gcode_t           sel_code;
    logic             sel_gate;
    logic [SEG_W-1:0] seg_d;
    logic [SEG_W-1:0] seg_q;
    drive_t           drv_d;
    drive_t           drv_q;

    gsd_scan_timer #(
        .TICK_DIV (TICK_DIV),
        .SLOT_BITS(SLOT_BITS),
        .BLANK    (BLANK)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .dup_sel(dup_sel),
        .bright (bright),
        .gidx   (gidx),
        .active (active)
    );

    // Master follows its own scan; follower follows the cascade inputs.
    assign sel_code = master ? gidx   : gcode_t'(sync_in);
    assign sel_gate = master ? active : dim_in;

    gsd_row_pick #(.SEG_W(SEG_W)) u_pick (
        .row0(row0),
        .row1(row1),
        .row2(row2),
        .code(sel_code),
        .gate(sel_gate),
        .seg (seg_d)
    );

    always_comb begin
        drv_d = DRIVE_IDLE;
        if (master) begin
            drv_d.code = gidx;
            drv_d.dim  = active;
            if (active) drv_d.grid_n = ~grid_sel(gidx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= '0;
            drv_q <= DRIVE_IDLE;
        end else begin
            seg_q <= seg_d;
            drv_q <= drv_d;
        end
    end

    assign seg      = seg_q;
    assign grid_n   = drv_q.grid_n;
    assign dim_out  = drv_q.dim;
    assign sync_out = drv_q.code;

endmodule

module gsd_scanner_chk #(
    parameter int SEG_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             master,
    input logic [1:0]       sync_in,
    input logic [SEG_W-1:0] seg,
    input logic [2:0]       grid_n,
    input logic             dim_out,
    input logic [1:0]       sync_out
);
    AST_ONE_GRID_LIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~grid_n)); // R6

    AST_WINDOW_MATCHES_GRID: assert property (@(posedge clk) disable iff (rst)
        dim_out == (grid_n != 3'b111)); // R8

    AST_THIRD_GRID_CODE: assert property (@(posedge clk) disable iff (rst)
        !grid_n[2] |-> sync_out == 2'd2); // R8

    AST_DARK_SEGMENTS: assert property (@(posedge clk) disable iff (rst)
        ($past(master) && grid_n == 3'b111) |-> seg == '0); // R7

    AST_FOLLOWER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !master |=> (grid_n == 3'b111 && !dim_out && sync_out == 2'd0)); // R12

    AST_FOLLOWER_BLANK_CODE: assert property (@(posedge clk) disable iff (rst)
        (!master && sync_in == 2'b11) |=> seg == '0); // R11

endmodule

bind gsd_scanner gsd_scanner_chk #(.SEG_W(SEG_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .master  (master),
    .sync_in (sync_in),
    .seg     (seg),
    .grid_n  (grid_n),
    .dim_out (dim_out),
    .sync_out(sync_out)
);

// File: tb/sim_gsd_scanner.sv
module sim_gsd_scanner;
    localparam int CLK_P = 10;
    localparam int SEG_W = 32;
    localparam int TK    = 2;
    localparam int SB    = 5;
    localparam int BL    = 8;
    localparam int SLOT  = 1 << SB;
    localparam int WIN   = 6 * SLOT * TK;
    localparam int NV    = 7;

    // {dup_sel, bright, expected lit bit times}
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 5'd0,  5'd0},
        {1'b0, 5'd5,  5'd5},
        {1'b1, 5'd12, 5'd12},
        {1'b0, 5'd24, 5'd24},
        {1'b1, 5'd25, 5'd24},
        {1'b0, 5'd31, 5'd24},
        {1'b1, 5'd1,  5'd1}
    };

    localparam logic [SEG_W-1:0] P0 = 32'hA5A5_0001;
    localparam logic [SEG_W-1:0] P1 = 32'h0F0F_1234;
    localparam logic [SEG_W-1:0] P2 = 32'h8000_FFFF;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             master = 1'b1;
    logic             dup_sel = 1'b0;
    logic [SB-1:0]    bright = '0;
    logic [SEG_W-1:0] row0 = P0;
    logic [SEG_W-1:0] row1 = P1;
    logic [SEG_W-1:0] row2 = P2;
    logic             dim_in = 1'b0;
    logic [1:0]       sync_in = 2'b00;
    logic [SEG_W-1:0] seg;
    logic [2:0]       grid_n;
    logic             dim_out;
    logic [1:0]       sync_out;

    int errors = 0;
    int checks = 0;

    always #(CLK_P/2) clk = ~clk;

    gsd_scanner #(.SEG_W(SEG_W), .TICK_DIV(TK), .SLOT_BITS(SB), .BLANK(BL)) u0 (
        .clk(clk), .rst(rst), .master(master), .dup_sel(dup_sel), .bright(bright),
        .row0(row0), .row1(row1), .row2(row2), .dim_in(dim_in), .sync_in(sync_in),
        .seg(seg), .grid_n(grid_n), .dim_out(dim_out), .sync_out(sync_out)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [SEG_W-1:0] row_of(input logic [1:0] c);
        case (c)
            2'd0:    return P0;
            2'd1:    return P1;
            2'd2:    return P2;
            default: return '0;
        endcase
    endfunction

    // Over six slots: lit time per grid, code dwell, segment and window agreement.
    task automatic measure(input logic dup, input int exp_on, input int v);
        int ng;
        int lit_c [3];
        int code_c [4];
        int seg_bad, dim_bad, multi;
        logic [2:0] lows;
        ng = dup ? 2 : 3;
        lit_c = '{0, 0, 0};
        code_c = '{0, 0, 0, 0};
        seg_bad = 0; dim_bad = 0; multi = 0;
        for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            lows = ~grid_n;
            for (int k = 0; k < 3; k++) if (lows[k]) lit_c[k]++;
            code_c[sync_out]++;
            if ($countones(lows) > 1) multi++;
            if (lows == 3'b000) begin
                if (seg != '0) seg_bad++;
            end else if (lows != (3'b001 << sync_out) || seg != row_of(sync_out)) begin
                seg_bad++;
            end
            if (dim_out != (lows != 3'b000)) dim_bad++;
            // R9: cascade inputs wander while in master role
            dim_in  = ~dim_in;
            sync_in = sync_in + 2'd1;
        end
        for (int k = 0; k < 3; k++) begin
            // R4 and R5 on lit time; R3 on the unused third grid
            chk((k == 2 && dup) ? "R3" : "R4/R5", $sformatf("vec %0d grid %0d lit clocks", v, k),
                lit_c[k], (k < ng) ? exp_on * TK * (6 / ng) : 0);
            chk((k == 2 && dup) ? "R3" : "R2", $sformatf("vec %0d code %0d dwell", v, k),
                code_c[k], (k < ng) ? WIN / ng : 0);
        end
        chk("R2", $sformatf("vec %0d code 3 dwell", v), code_c[3], 0);
        chk("R6", $sformatf("vec %0d multiple grids lit", v), multi, 0);
        chk("R7", $sformatf("vec %0d segment mismatches", v), seg_bad, 0);
        chk("R8", $sformatf("vec %0d window mismatches", v), dim_bad, 0);
        chk("R9", $sformatf("vec %0d mismatches under wandering inputs", v), seg_bad + dim_bad, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int dark;
        // R1: outputs during reset
        bright = 5'd20;
        repeat (2) @(negedge clk);
        chk("R1", "seg in reset", seg, 0);
        chk("R1", "grid_n in reset", grid_n, 3'b111);
        chk("R1", "dim_out in reset", dim_out, 0);
        chk("R1", "sync_out in reset", sync_out, 0);
        do_reset();
        // R1: captured brightness starts at zero, so the first slot is dark
        dark = 0;
        for (int c = 0; c < SLOT * TK - 4; c++) begin
            @(negedge clk);
            if (grid_n != 3'b111 || seg != '0) dark++;
        end
        chk("R1", "lit samples in first slot", dark, 0);

        for (int v = 0; v < NV; v++) begin
            dup_sel = VEC[v][10];
            bright  = VEC[v][9:5];
            do_reset();
            repeat (400) @(negedge clk);
            measure(VEC[v][10], int'(VEC[v][4:0]), v);
        end

        // Follower role
        master = 1'b0;
        do_reset();
        sync_in = 2'd0; dim_in = 1'b1; repeat (2) @(negedge clk);
        chk("R10", "code 0 lit", seg, P0);
        sync_in = 2'd1; repeat (2) @(negedge clk);
        chk("R10", "code 1 lit", seg, P1);
        sync_in = 2'd2; repeat (2) @(negedge clk);
        chk("R10", "code 2 lit", seg, P2);
        sync_in = 2'd1; dim_in = 1'b0; repeat (2) @(negedge clk);
        chk("R10", "code 1 window low", seg, 0);
        sync_in = 2'd3; dim_in = 1'b1; repeat (2) @(negedge clk);
        chk("R11", "code 3 blanks", seg, 0);
        chk("R12", "follower grid_n", grid_n, 3'b111);
        chk("R12", "follower dim_out", dim_out, 0);
        chk("R12", "follower sync_out", sync_out, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule